// File: doc/BRIEF.md
# Pipelined CORDIC Array Engine with Result Queue

This block computes circular CORDIC functions for arrays of arguments. A processor issues one argument set per clock (a function code, two Q2.13 operands and a 15-bit phase word). A fully unrolled cascade of fifteen iteration stages works on it while later arguments follow behind. Each stage carries a valid bit and a function code with its data, so every finished result knows which output word it has to produce.

Finished words go into a 32-entry queue that the processor drains with a pop strobe at whatever rate suits it. The issue port drops its ready signal whenever the queue, counting the results already inside the cascade, could not take one more worst-case result. So the engine never loses a result, however slowly it is drained. A rotation yields two queue words, x before y. All outputs have the gain of the iterations removed.

Top module: `cordic_array_engine`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0, `q_count`=0), `iss_ready`=1 and `q_underflow`=0.
- R2: Code 0 yields cos and code 1 yields sin of the angle `iss_phase`·π/2^14, over the whole range −2^14..2^14−1 of the phase word. The result is a 16-bit two's complement word with 13 fraction bits, within 6 LSB of the exact value.
- R3: Code 2 yields a·cos and code 3 yields a·sin, where a is `iss_a` read as a signed word with 13 fraction bits. The error limit of R2 applies.
- R4: Code 4 (rotate) writes two consecutive queue words: first a·cos − b·sin, then b·cos + a·sin, where b is `iss_b`. The error limit of R2 applies.
- R5: A result enters the queue on the 15th rising edge after the edge that accepted its arguments. `q_count` goes from 0 to 1 at that edge and not earlier.
- R6: While the queue is being drained every cycle, a stream of single-word functions is accepted at one argument per clock with no stall.
- R7: Issue is accepted only when `iss_valid` and `iss_ready` are both 1. `iss_ready` is 1 exactly when queue count plus words in flight plus 2 is at most 32. With no draining, back-to-back rotations stop after 16 are accepted, and the queue fills to 32 without losing a word.
- R8: The queue returns words in issue order. A pop with the queue not empty places the oldest word on `q_data` at that clock edge. `q_full` and `q_empty` track `q_count`.
- R9: A pop while the queue is empty leaves `q_data` unchanged and sets `q_underflow`, which stays 1 until reset.
- R10: Codes 5 to 7 are accepted but produce no queue word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Argument set offered |
| iss_ready | output | 1 | Engine can take an argument set this cycle |
| iss_fn | input | 3 | Function code (0 cos, 1 sin, 2 a·cos, 3 a·sin, 4 rotate) |
| iss_a | input | 16 | Operand a (amplitude or x), Q2.13 |
| iss_b | input | 16 | Operand b (y for rotate), Q2.13 |
| iss_phase | input | 15 | Signed angle, unit π/2^14 |
| q_pop | input | 1 | Remove the oldest queue word |
| q_data | output | 16 | Last popped word, Q2.13 |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue holds 32 words |
| q_count | output | 6 | Number of words in the queue |
| q_underflow | output | 1 | Sticky: a pop arrived while the queue was empty |

## Verification
The bench sweeps phases on both sides of ±π/2 and at −π. Missing quadrant folding there gives results that are wrong in sign or magnitude. It floods the engine with rotations and never pops, then checks that exactly 16 are taken and all 32 words come back in order. A reservation that counts only queue occupancy would overrun and lose words, and a wrong x/y order would fail the scoreboard. It also counts the cycles to the first queue word, pops an empty queue, and issues an undefined code. These catch an off-by-one stage count, a data word clobbered by an underflow pop, and a spurious word written for an unknown code.

// File: rtl/cordic_array_engine.sv
module cordic_array_engine #(
  parameter int STAGES = 15,
  parameter int DEPTH  = 32,
  parameter int DW     = 16,
  parameter int FRAC   = 13,
  parameter int PW     = 15,
  parameter int GX     = 3,
  parameter int GZ     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          iss_valid,
  output logic                          iss_ready,
  input  logic [2:0]                    iss_fn,
  input  logic [DW-1:0]                 iss_a,
  input  logic [DW-1:0]                 iss_b,
  input  logic [PW-1:0]                 iss_phase,
  input  logic                          q_pop,
  output logic [DW-1:0]                 q_data,
  output logic                          q_empty,
  output logic                          q_full,
  output logic [$clog2(DEPTH+1)-1:0]    q_count,
  output logic                          q_underflow
);
  localparam int IW = DW + 2 + GX;
  localparam int ZW = PW + GZ + 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);
  localparam int LAST = STAGES - 1;
  localparam logic [2:0] FN_SIN = 3'd1, FN_ASIN = 3'd3, FN_ROT = 3'd4;
  localparam logic signed [IW-1:0] ONE = IW'(1) << (FRAC + GX);
  localparam logic signed [ZW-1:0] ZPI = ZW'(1) << (PW + GZ - 1);
  localparam logic signed [ZW-1:0] ZHALF = ZPI >>> 1;
  localparam logic signed [17:0] KINV = 18'sd39797;

  function automatic logic signed [ZW-1:0] atan_step(input int k);
    longint v;
    case (k)
      0: v = 65536;  1: v = 38688;  2: v = 20442;  3: v = 10377;
      4: v = 5208;   5: v = 2607;   6: v = 1304;   7: v = 652;
      8: v = 326;    9: v = 163;   10: v = 81;    11: v = 41;
      12: v = 20;   13: v = 10;    14: v = 5;
      default: v = 0;
    endcase
    return ZW'((v * (longint'(1) << (PW + GZ - 1))) >>> 18);
  endfunction

  function automatic logic signed [DW-1:0] descale(input logic signed [IW-1:0] v);
    logic signed [IW+17:0] p;
    p = (IW+18)'(v) * (IW+18)'(KINV);
    return DW'(p >>> (16 + GX));
  endfunction

  logic signed [IW-1:0] a_ext, b_ext, x_raw, y_raw, x_in, y_in;
  logic signed [ZW-1:0] z_raw, z_in;
  logic flip, take;
  logic [1:0] cost_in, wr_cnt;

  assign a_ext = IW'($signed(iss_a)) <<< GX;
  assign b_ext = IW'($signed(iss_b)) <<< GX;
  assign z_raw = ZW'($signed(iss_phase)) <<< GZ;
  assign x_raw = (iss_fn < 3'd2) ? ONE : a_ext;
  assign y_raw = (iss_fn == FN_ROT) ? b_ext : '0;
  assign flip  = (z_raw > ZHALF) || (z_raw < -ZHALF);
  assign x_in  = flip ? -x_raw : x_raw;
  assign y_in  = flip ? -y_raw : y_raw;
  assign z_in  = !flip ? z_raw : (z_raw > 0) ? z_raw - ZPI : z_raw + ZPI;
  assign take  = iss_valid && iss_ready && (iss_fn <= FN_ROT);
  assign cost_in = !take ? 2'd0 : (iss_fn == FN_ROT) ? 2'd2 : 2'd1;

  logic signed [IW-1:0] st_x [STAGES], st_y [STAGES], sx [STAGES], sy [STAGES];
  logic signed [IW-1:0] nx [STAGES], ny [STAGES];
  logic signed [ZW-1:0] st_z [STAGES], sz [STAGES], nz [STAGES];
  logic [2:0]           st_f [STAGES];
  logic                 st_v [STAGES];

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      sx[i] = (i == 0) ? x_in : st_x[(i == 0) ? 0 : i-1];
      sy[i] = (i == 0) ? y_in : st_y[(i == 0) ? 0 : i-1];
      sz[i] = (i == 0) ? z_in : st_z[(i == 0) ? 0 : i-1];
      if (!sz[i][ZW-1]) begin
        nx[i] = sx[i] - (sy[i] >>> i);
        ny[i] = sy[i] + (sx[i] >>> i);
        nz[i] = sz[i] - atan_step(i);
      end else begin
        nx[i] = sx[i] + (sy[i] >>> i);
        ny[i] = sy[i] - (sx[i] >>> i);
        nz[i] = sz[i] + atan_step(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < STAGES; i++) begin
      st_x[i] <= nx[i];
      st_y[i] <= ny[i];
      st_z[i] <= nz[i];
      if (!rst_n) begin
        st_v[i] <= 1'b0;
        st_f[i] <= '0;
      end else begin
        st_v[i] <= (i == 0) ? take   : st_v[(i == 0) ? 0 : i-1];
        st_f[i] <= (i == 0) ? iss_fn : st_f[(i == 0) ? 0 : i-1];
      end
    end
  end

  logic signed [DW-1:0] out_x, out_y, word0;
  assign out_x = descale(st_x[LAST]);
  assign out_y = descale(st_y[LAST]);
  assign word0 = (st_f[LAST] == FN_SIN || st_f[LAST] == FN_ASIN) ? out_y : out_x;
  assign wr_cnt = !st_v[LAST] ? 2'd0 : (st_f[LAST] == FN_ROT) ? 2'd2 : 2'd1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] inflight;
  logic pop_ok;

  assign pop_ok    = q_pop && (q_count != 0);
  assign q_empty   = (q_count == 0);
  assign q_full    = (int'(q_count) == DEPTH);
  assign iss_ready = (int'(q_count) + int'(inflight) + 2) <= DEPTH;

  always_ff @(posedge clk) begin
    if (wr_cnt != 2'd0) mem[wptr] <= word0;
    if (wr_cnt == 2'd2) mem[wptr + AW'(1)] <= out_y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      q_count <= '0;
      inflight <= '0;
      q_data <= '0;
      q_underflow <= 1'b0;
    end else begin
      wptr <= wptr + AW'(wr_cnt);
      rptr <= rptr + AW'(pop_ok);
      q_count <= q_count + CW'(wr_cnt) - CW'(pop_ok);
      inflight <= inflight + CW'(cost_in) - CW'(wr_cnt);
      if (pop_ok) q_data <= mem[rptr];
      if (q_pop && q_count == 0) q_underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/cordic_array_engine_chk.sv
module cordic_array_engine_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       iss_ready,
  input logic                       q_pop,
  input logic [DW-1:0]              q_data,
  input logic                       q_empty,
  input logic                       q_full,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       q_underflow,
  input logic [1:0]                 wr_cnt,
  input logic [$clog2(DEPTH+1)-1:0] inflight
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt != 2'd0) |-> (int'(q_count) + int'(wr_cnt) <= DEPTH));
  a_r7_reserve_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_count) + int'(inflight)) <= DEPTH);
  a_r6_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == 0 && inflight == 0) |-> iss_ready);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(q_count) <= int'($past(q_count)) + 2) && (int'(q_count) + 1 >= int'($past(q_count))));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q_underflow |=> q_underflow);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_empty) |=> $stable(q_data));
endmodule

bind cordic_array_engine cordic_array_engine_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ready(iss_ready), .q_pop(q_pop), .q_data(q_data),
  .q_empty(q_empty), .q_full(q_full), .q_count(q_count), .q_underflow(q_underflow),
  .wr_cnt(wr_cnt), .inflight(inflight)
);

// File: tb/cordic_array_engine_bench.sv
module cordic_array_engine_bench;
  localparam int TOL = 6;
  localparam real PI = 3.14159265358979;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, q_pop = 0;
  logic [2:0] iss_fn = 0;
  logic [15:0] iss_a = 0, iss_b = 0, q_data;
  logic [14:0] iss_phase = 0;
  logic iss_ready, q_empty, q_full, q_underflow;
  logic [5:0] q_count;

  int checks = 0, fails = 0, stalls = 0;
  int exp_q[$];
  string tag_q[$];
  bit drain_en = 0, force_pop = 0, pend = 0;

  always #2 clk = ~clk;

  cordic_array_engine u_cordic_array_engine (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_fn(iss_fn), .iss_a(iss_a), .iss_b(iss_b), .iss_phase(iss_phase),
    .q_pop(q_pop), .q_data(q_data), .q_empty(q_empty), .q_full(q_full),
    .q_count(q_count), .q_underflow(q_underflow));

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  task automatic push_expect(input logic [2:0] fn, input int a, input int b, input int ph);
    real th, c, s;
    th = real'(ph) * PI / 16384.0;
    c = $cos(th);
    s = $sin(th);
    case (fn)
      3'd0: begin exp_q.push_back(rnd(8192.0 * c)); tag_q.push_back("R2 cos"); end
      3'd1: begin exp_q.push_back(rnd(8192.0 * s)); tag_q.push_back("R2 sin"); end
      3'd2: begin exp_q.push_back(rnd(real'(a) * c)); tag_q.push_back("R3 acos"); end
      3'd3: begin exp_q.push_back(rnd(real'(a) * s)); tag_q.push_back("R3 asin"); end
      3'd4: begin
        exp_q.push_back(rnd(real'(a) * c - real'(b) * s)); tag_q.push_back("R4 x");
        exp_q.push_back(rnd(real'(b) * c + real'(a) * s)); tag_q.push_back("R4 y");
      end
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] fn, input int a, input int b, input int ph);
    @(negedge clk);
    while (!iss_ready) begin
      iss_valid = 0;
      stalls++;
      @(negedge clk);
    end
    iss_valid = 1; iss_fn = fn;
    iss_a = 16'(a); iss_b = 16'(b); iss_phase = 15'(ph);
    push_expect(fn, a, b, ph);
  endtask

  task automatic idle();
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic wait_drained();
    for (int k = 0; k < 400 && (exp_q.size() != 0 || !q_empty); k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected words returned", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (pend) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected word", int'($signed(q_data)), 0);
      else begin
        int e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = int'($signed(q_data));
        chk((g - e <= TOL) && (e - g <= TOL), t, g, e);
      end
    end
    q_pop = (drain_en && !q_empty) || force_pop;
    pend = drain_en && !q_empty;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  int ph_list[12] = '{-16384, -12000, -8192, -5000, -1, 0, 1, 3000, 8191, 8192, 12345, 16383};

  initial begin
    int acc;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(q_empty == 1, "R1 empty", q_empty, 1);
    chk(q_full == 0, "R1 full", q_full, 0);
    chk(q_count == 0, "R1 count", q_count, 0);
    chk(iss_ready == 1, "R1 ready", iss_ready, 1);
    chk(q_underflow == 0, "R1 underflow", q_underflow, 0);

    // R9: pop while empty
    force_pop = 1;
    @(negedge clk);
    force_pop = 0;
    @(negedge clk);
    chk(q_underflow == 1, "R9 underflow set", q_underflow, 1);
    chk(q_data == 0, "R9 data held", q_data, 0);
    repeat (3) @(negedge clk);
    chk(q_underflow == 1, "R9 underflow sticky", q_underflow, 1);

    // R5: latency
    issue(3'd0, 0, 0, 0);
    idle();
    repeat (14) @(negedge clk);
    chk(q_count == 0, "R5 no word before 15 edges", q_count, 0);
    @(negedge clk);
    chk(q_count == 1, "R5 word after 15 edges", q_count, 1);
    drain_en = 1;
    wait_drained();

    // R2 and R6: cos/sin stream while draining
    stalls = 0;
    foreach (ph_list[k]) issue(3'd0, 0, 0, ph_list[k]);
    foreach (ph_list[k]) issue(3'd1, 0, 0, ph_list[k]);
    idle();
    chk(stalls == 0, "R6 no stalls while draining", stalls, 0);
    wait_drained();

    // R3, R4
    foreach (ph_list[k]) issue(3'd2, -13000, 0, ph_list[k]);
    foreach (ph_list[k]) issue(3'd3, 15000, 0, ph_list[k]);
    foreach (ph_list[k]) issue(3'd4, 9000, -7000, ph_list[k]);
    idle();
    wait_drained();

    // R7: back-pressure with no draining
    drain_en = 0;
    acc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      iss_valid = 1; iss_fn = 3'd4;
      iss_a = 16'(8000); iss_b = 16'(3000); iss_phase = 15'(k * 1500 - 9000);
      if (iss_ready) begin
        acc++;
        push_expect(3'd4, 8000, 3000, k * 1500 - 9000);
      end
    end
    idle();
    chk(acc == 16, "R7 rotations accepted", acc, 16);
    repeat (20) @(negedge clk);
    chk(q_count == 32, "R7 queue filled", q_count, 32);
    chk(q_full == 1, "R8 full flag", q_full, 1);
    chk(iss_ready == 0, "R7 ready low when full", iss_ready, 0);
    drain_en = 1;
    wait_drained();
    chk(q_empty == 1, "R8 empty after drain", q_empty, 1);

    // R10: undefined code
    drain_en = 0;
    issue(3'd5, 1000, 1000, 100);
    issue(3'd7, 1000, 1000, 100);
    idle();
    repeat (20) @(negedge clk);
    chk(q_count == 0, "R10 no word for codes 5-7", q_count, 0);
    chk(iss_ready == 1, "R10 ready after undefined codes", iss_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule